// File: doc/BRIEF.md
# Master PWM Phase Timer

This block is the single time base of a multi-phase PWM system. A 16-bit up counter runs from zero to a programmable period and wraps. Four compare units watch the counter. Each one raises an event in the cycle where the counter equals its value. Every event can be routed to set or clear any of twelve PWM output latches. Each event can also be routed to any of six sync lines that restart or align dependent timing units. Because one counter drives every phase, the spacing between the compare values fixes the phase shifts between the units, as an interleaved converter needs.

The period and compare inputs are shadow values. They reach the active registers only at a wrap or while the timer is stopped, so a change in mid-period never cuts a PWM cycle short. Routing masks and the enable act at once. When a set and a clear reach the same output in the same cycle, the clear wins.

Top module: `master_phase_timer`

## Requirements
- R1: While `enable` is high and the count is below the active period, `count` rises by exactly one on each clock edge.
- R2: In the cycle where an enabled counter equals the active period, `rollover` is high, and `count` is 0 in the following cycle.
- R3: `cmpEvent[k]` is high exactly in the enabled cycles where `count` equals active compare value k. A compare value above the active period never fires, because `count` never exceeds the active period.
- R4: The active period and compare values are taken from `periodIn` and `cmpValIn` (value k in bits `[16k+15:16k]`) on the clock edge that ends a rollover cycle, and on every edge while `enable` is low. Shadow changes at any other time have no effect on `count` or on the events.
- R5: `rstReq[i]` is the OR over all events k of `cmpEvent[k] & rstMaskIn[k*12+i]`. `setReq[i]` is the same OR over `setMaskIn[k*12+i]`, forced low whenever `rstReq[i]` is high.
- R6: `pwmOut[i]` becomes 0 on the edge after `rstReq[i]` is high and becomes 1 on the edge after `setReq[i]` is high. Otherwise it holds its value, so a clear always wins over a set in the same cycle.
- R7: `syncPulse[j]` is the OR over all events k of `cmpEvent[k] & syncMaskIn[k*6+j]`.
- R8: While `enable` is low, `cmpEvent`, `rollover`, `setReq`, `rstReq` and `syncPulse` are all 0, `count` is 0 from the next cycle on, and `pwmOut` holds its value.
- R9: After reset, `count`, `pwmOut` and the active period and compare values are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the counter and allows events |
| periodIn | input | 16 | Shadow period (last count value before the wrap) |
| cmpValIn | input | 64 | Four shadow compare values, 16 bits each |
| setMaskIn | input | 48 | Set routing, bit k*12+i: event k sets output i |
| rstMaskIn | input | 48 | Clear routing, bit k*12+i: event k clears output i |
| syncMaskIn | input | 24 | Sync routing, bit k*6+j: event k pulses sync line j |
| count | output | 16 | Current counter value |
| cmpEvent | output | 4 | Compare event per compare unit |
| rollover | output | 1 | Period wrap pulse |
| setReq | output | 12 | Set request per output, after clear priority |
| rstReq | output | 12 | Clear request per output |
| syncPulse | output | 6 | Sync pulse per dependent timing unit |
| pwmOut | output | 12 | PWM output latches |

## Verification
A wrong active period or a missed shadow load shows on `count` within one period: the wrap lands in the wrong cycle and `rollover` moves with it. A corrupted active compare value moves `cmpEvent`, the requests and the sync pulses in that same period. A wrong output latch shows on `pwmOut` one cycle after the event that should have set or cleared it. Because the reference model is compared on every clock, any divergence is reported in the first cycle where it reaches a port.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic cntClear;    // force counter to zero on the next edge
    logic cntInc;      // advance counter on the next edge
    logic shadowLoad;  // copy shadow period/compare into active registers
    logic evtEn;       // allow compare and wrap events this cycle
  } mptStrobes_t;

endpackage

// File: rtl/mpt_ctrl.sv
module mpt_ctrl
  import mpt_pkg::*;
(
  input  logic        enable,
  input  logic        periodMatch,
  output mptStrobes_t strb
);

  logic wrapNow;

  assign wrapNow = enable & periodMatch;

  always_comb begin
    strb.evtEn      = enable;
    strb.cntInc     = enable & ~periodMatch;
    strb.cntClear   = ~enable | wrapNow;
    strb.shadowLoad = ~enable | wrapNow;
  end

endmodule

// File: rtl/mpt_datapath.sv
module mpt_datapath
  import mpt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  mptStrobes_t              strb,
  input  logic [CNT_W-1:0]         periodIn,
  input  logic [NUM_CMP*CNT_W-1:0] cmpValIn,
  output logic [CNT_W-1:0]         count,
  output logic [CNT_W-1:0]         actPeriod,
  output logic                     periodMatch,
  output logic [NUM_CMP-1:0]       cmpEvent,
  output logic                     rollover
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] perQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strb.cntClear) begin
      cntQ <= '0;
    end else if (strb.cntInc) begin
      cntQ <= cntQ + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perQ <= '0;
    end else if (strb.shadowLoad) begin
      perQ <= periodIn;
    end
  end

  assign periodMatch = (cntQ == perQ);
  assign rollover    = strb.evtEn & periodMatch;
  assign count       = cntQ;
  assign actPeriod   = perQ;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] cmpQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmpQ <= '0;
      end else if (strb.shadowLoad) begin
        cmpQ <= cmpValIn[k*CNT_W +: CNT_W];
      end
    end

    assign cmpEvent[k] = strb.evtEn & (cntQ == cmpQ);
  end

endmodule

// File: rtl/mpt_router.sv
module mpt_router #(
  parameter int NUM_CMP  = 4,
  parameter int NUM_OUT  = 12,
  parameter int NUM_SYNC = 6
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CMP-1:0]          cmpEvent,
  input  logic [NUM_CMP*NUM_OUT-1:0]  setMaskIn,
  input  logic [NUM_CMP*NUM_OUT-1:0]  rstMaskIn,
  input  logic [NUM_CMP*NUM_SYNC-1:0] syncMaskIn,
  output logic [NUM_OUT-1:0]          setReq,
  output logic [NUM_OUT-1:0]          rstReq,
  output logic [NUM_SYNC-1:0]         syncPulse,
  output logic [NUM_OUT-1:0]          pwmOut
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic [NUM_CMP-1:0] setHits;
    logic [NUM_CMP-1:0] rstHits;
    logic               latchQ;

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_src
      assign setHits[k] = cmpEvent[k] & setMaskIn[k*NUM_OUT + i];
      assign rstHits[k] = cmpEvent[k] & rstMaskIn[k*NUM_OUT + i];
    end

    assign rstReq[i] = |rstHits;
    assign setReq[i] = (|setHits) & ~(|rstHits);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latchQ <= 1'b0;
      end else if (rstReq[i]) begin
        latchQ <= 1'b0;
      end else if (setReq[i]) begin
        latchQ <= 1'b1;
      end
    end

    assign pwmOut[i] = latchQ;
  end

  for (genvar j = 0; j < NUM_SYNC; j++) begin : g_sync
    logic [NUM_CMP-1:0] syncHits;
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_src
      assign syncHits[k] = cmpEvent[k] & syncMaskIn[k*NUM_SYNC + j];
    end
    assign syncPulse[j] = |syncHits;
  end

endmodule

// File: rtl/master_phase_timer.sv
module master_phase_timer
  import mpt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_CMP  = 4,
  parameter int NUM_OUT  = 12,
  parameter int NUM_SYNC = 6
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic [CNT_W-1:0]            periodIn,
  input  logic [NUM_CMP*CNT_W-1:0]    cmpValIn,
  input  logic [NUM_CMP*NUM_OUT-1:0]  setMaskIn,
  input  logic [NUM_CMP*NUM_OUT-1:0]  rstMaskIn,
  input  logic [NUM_CMP*NUM_SYNC-1:0] syncMaskIn,
  output logic [CNT_W-1:0]            count,
  output logic [NUM_CMP-1:0]          cmpEvent,
  output logic                        rollover,
  output logic [NUM_OUT-1:0]          setReq,
  output logic [NUM_OUT-1:0]          rstReq,
  output logic [NUM_SYNC-1:0]         syncPulse,
  output logic [NUM_OUT-1:0]          pwmOut
);

  mptStrobes_t      strb;
  logic             periodMatch;
  logic [CNT_W-1:0] actPeriod;

  mpt_ctrl u_ctrl (
    .enable      (enable),
    .periodMatch (periodMatch),
    .strb        (strb)
  );

  mpt_datapath #(
    .CNT_W   (CNT_W),
    .NUM_CMP (NUM_CMP)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .periodIn    (periodIn),
    .cmpValIn    (cmpValIn),
    .count       (count),
    .actPeriod   (actPeriod),
    .periodMatch (periodMatch),
    .cmpEvent    (cmpEvent),
    .rollover    (rollover)
  );

  mpt_router #(
    .NUM_CMP  (NUM_CMP),
    .NUM_OUT  (NUM_OUT),
    .NUM_SYNC (NUM_SYNC)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmpEvent   (cmpEvent),
    .setMaskIn  (setMaskIn),
    .rstMaskIn  (rstMaskIn),
    .syncMaskIn (syncMaskIn),
    .setReq     (setReq),
    .rstReq     (rstReq),
    .syncPulse  (syncPulse),
    .pwmOut     (pwmOut)
  );

endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
  parameter int CNT_W    = 16,
  parameter int NUM_CMP  = 4,
  parameter int NUM_OUT  = 12,
  parameter int NUM_SYNC = 6
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W-1:0]     actPeriod,
  input logic [NUM_CMP-1:0]   cmpEvent,
  input logic                 rollover,
  input logic [NUM_OUT-1:0]   setReq,
  input logic [NUM_OUT-1:0]   rstReq,
  input logic [NUM_SYNC-1:0]  syncPulse,
  input logic [NUM_OUT-1:0]   pwmOut
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !rollover) |=> (count == CNT_W'($past(count) + 1'b1))); // R1

  AST_ROLL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (count == '0)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= actPeriod); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq != '0) |=> ((pwmOut & $past(rstReq)) == '0)); // R6

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (setReq != '0) |=> ((~pwmOut & $past(setReq)) == '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (cmpEvent == '0 && !rollover && setReq == '0 &&
                 rstReq == '0 && syncPulse == '0)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pwmOut)); // R8

endmodule

bind master_phase_timer mpt_checker #(
  .CNT_W    (CNT_W),
  .NUM_CMP  (NUM_CMP),
  .NUM_OUT  (NUM_OUT),
  .NUM_SYNC (NUM_SYNC)
) u_mpt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .count     (count),
  .actPeriod (actPeriod),
  .cmpEvent  (cmpEvent),
  .rollover  (rollover),
  .setReq    (setReq),
  .rstReq    (rstReq),
  .syncPulse (syncPulse),
  .pwmOut    (pwmOut)
);

// File: tb/test_master_phase_timer.sv
module test_master_phase_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NO = 12;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [15:0]   periodIn = '0;
  logic [63:0]   cmpValIn = '0;
  logic [47:0]   setMaskIn = '0;
  logic [47:0]   rstMaskIn = '0;
  logic [23:0]   syncMaskIn = '0;
  logic [15:0]   count;
  logic [3:0]    cmpEvent;
  logic          rollover;
  logic [11:0]   setReq, rstReq, pwmOut;
  logic [5:0]    syncPulse;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  // reference model state
  int          mCnt, mPer;
  int          mCmp [NC];
  logic [11:0] mPwm;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  master_phase_timer i_master_phase_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .periodIn(periodIn),
    .cmpValIn(cmpValIn), .setMaskIn(setMaskIn), .rstMaskIn(rstMaskIn),
    .syncMaskIn(syncMaskIn), .count(count), .cmpEvent(cmpEvent),
    .rollover(rollover), .setReq(setReq), .rstReq(rstReq),
    .syncPulse(syncPulse), .pwmOut(pwmOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // compare the ports with the model for the current cycle, then advance it
  task automatic checkCycle();
    logic [3:0]  ev;
    logic        roll;
    logic [11:0] sh, rh;
    logic [5:0]  sy;
    roll = enable && (mCnt == mPer);
    for (int k = 0; k < NC; k++) ev[k] = enable && (mCnt == mCmp[k]);
    sh = '0; rh = '0; sy = '0;
    for (int k = 0; k < NC; k++) begin
      for (int i = 0; i < NO; i++) begin
        if (ev[k] && setMaskIn[k*NO+i]) sh[i] = 1'b1;
        if (ev[k] && rstMaskIn[k*NO+i]) rh[i] = 1'b1;
      end
      for (int j = 0; j < NS; j++)
        if (ev[k] && syncMaskIn[k*NS+j]) sy[j] = 1'b1;
    end
    chk("R1", "count", int'(count), mCnt);
    chk("R2", "rollover", int'(rollover), int'(roll));
    chk("R3", "cmpEvent", int'(cmpEvent), int'(ev));
    chk("R5", "rstReq", int'(rstReq), int'(rh));
    chk("R5", "setReq", int'(setReq), int'(sh & ~rh));
    chk("R7", "syncPulse", int'(syncPulse), int'(sy));
    chk("R6", "pwmOut", int'(pwmOut), int'(mPwm));
    if (!enable) chk("R8", "idle events", int'({cmpEvent, rollover, syncPulse}), 0);
    mPwm = (mPwm | sh) & ~rh;
    if (!enable || roll) begin
      mCnt = 0;
      mPer = int'(periodIn);
      for (int k = 0; k < NC; k++) mCmp[k] = int'(cmpValIn[k*16 +: 16]);
    end else begin
      mCnt = mCnt + 1;
    end
  endtask

  task automatic runCycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      #1;
      checkCycle();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "count in reset", int'(count), 0);
    chk("R9", "pwmOut in reset", int'(pwmOut), 0);
    mCnt = 0; mPer = 0; mPwm = '0;
    for (int k = 0; k < NC; k++) mCmp[k] = 0;
    rst_n = 1'b1;
    #1;
    checkCycle();   // R9: first cycle out of reset, active values zero

    // directed setup: period 9, compares 3,3,6,12 (12 exceeds period: R3)
    @(negedge clk);
    periodIn = 16'd9;
    cmpValIn = {16'd12, 16'd6, 16'd3, 16'd3};
    setMaskIn = '0; rstMaskIn = '0; syncMaskIn = '0;
    setMaskIn[0*NO +: NO] = 12'h03F;    // event 0 sets outputs 0..5
    rstMaskIn[1*NO + 4]   = 1'b1;       // event 1 clears output 4 (same cycle: R6)
    rstMaskIn[2*NO +: NO] = 12'hFFF;    // event 2 clears all
    setMaskIn[3*NO +: NO] = 12'hFFF;    // event 3 never fires
    syncMaskIn[0*NS + 0]  = 1'b1;
    syncMaskIn[2*NS + 3]  = 1'b1;
    syncMaskIn[3*NS + 5]  = 1'b1;
    #1; checkCycle();
    runCycles(4);                        // R8: idle, shadow loads

    @(negedge clk); enable = 1'b1; #1; checkCycle();
    runCycles(25);                       // R1 R2 R3 R5 R6 R7

    // R4: change shadow mid-period; must wait for the wrap
    @(negedge clk);
    periodIn = 16'd5;
    cmpValIn = {16'd1, 16'd4, 16'd2, 16'd0};
    #1; checkCycle();
    runCycles(30);

    // R8: stop mid-period, then restart
    @(negedge clk); enable = 1'b0; #1; checkCycle();
    runCycles(6);
    @(negedge clk); enable = 1'b1; periodIn = 16'd0; #1; checkCycle();
    runCycles(8);                        // R2: period 0 wraps every cycle

    // mixed patterns with shadow changes on arbitrary cycles
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      @(negedge clk);
      r = nextRand();
      enable = (r[3:0] != 4'h0);
      if (r[7:4] == 4'h5) periodIn = {11'd0, r[12:8]};
      if (r[15:13] == 3'd2) cmpValIn = {11'd0, r[20:16], 11'd0, r[25:21], 11'd0, nextRand()[4:0], 11'd0, nextRand()[9:5]};
      if (c % 64 == 0) begin
        setMaskIn  = {nextRand()[15:0], nextRand()};
        rstMaskIn  = {nextRand()[15:0], nextRand()} & {nextRand()[15:0], nextRand()};
        syncMaskIn = nextRand()[23:0];
      end
      #1;
      checkCycle();
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule